// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Interface

This block is the digital side of a four-channel, 16-bit converter with a parallel host bus. The host places a word on the bus, picks one of four channels with a two-bit address, and commits the word by ending a chip-select pulse with the read/write line low. The word lands in that channel's staging (input) register only. A separate load strobe then moves all four staging registers into the live (DAC) registers together, so every channel changes its code in the same clock cycle.

The host can read any staging register back over the same bus. A clear strobe zeroes the live rank and leaves the staging rank alone. A power-down level marks every output as high impedance and keeps the live codes, so they come back unchanged when power returns. Each channel's result is its 16-bit unsigned code plus a high-impedance flag. The analog path is outside this block.

All control pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer. Edges are found by comparing the synchronized level with a copy delayed by one cycle. The data bus is modelled as a separate input word, output word and output-enable signal.

Top module: `quad_dac_regs`

## Requirements
- R1: After the system reset all live codes are 0, no output is flagged high impedance and the bus is not driven.
- R2: A rising edge of `sel_n` while `rnw` is 0 stores `bus_in` into the staging register chosen by `addr` (0..3 maps to channel 0..3).
- R3: A live code changes only on a load or clear event. Writes to the staging rank alone leave `code_out` unchanged.
- R4: A rising edge of `load_in` copies all four staging registers into the live registers in one cycle, and the staging registers keep their contents.
- R5: A rising edge of `clr_in` sets all four live codes to 0 and leaves the staging registers unchanged.
- R6: When load and clear rising edges are seen in the same cycle, the clear wins and all live codes become 0.
- R7: While `sel_n` is 0 and `rnw` is 1, `bus_oe` is 1 and `bus_out` carries the staging register selected by `addr`.
- R8: While `sel_n` is 1 the bus is not driven (`bus_oe` is 0), and load, clear and power-down keep working.
- R9: While `pwr_n` is 0, all four bits of `out_hiz` are 1 and the live codes are held. When `pwr_n` returns to 1, the flags clear and the previous codes are still present.
- R10: A clear event during power-down still zeroes the live codes, so zeros appear when power-down is released.
- R11: A rising edge of `sel_n` while `rnw` is 1 (end of a read) writes nothing.
- R12: Codes are unsigned over the full range 0x0000 to 0xFFFF, and both extremes pass through staging, live and readback paths intact.
- R13: Every control change takes effect at the outputs on the third rising clock edge after it is applied, and not before.

`code_out` packs channel k in bits [16k+15:16k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system (power-on) reset, asynchronous |
| bus_in | input | 16 | Data bus word driven by the host |
| bus_out | output | 16 | Readback word driven by the block |
| bus_oe | output | 1 | 1 while the block drives the data bus |
| addr | input | 2 | Channel select |
| sel_n | input | 1 | Active-low chip select; rising edge commits a write |
| rnw | input | 1 | 1 = read, 0 = write |
| load_in | input | 1 | Rising edge transfers staging rank to live rank |
| clr_in | input | 1 | Rising edge zeroes the live rank |
| pwr_n | input | 1 | Active-low power-down level |
| code_out | output | 64 | Live codes of the four channels, packed |
| out_hiz | output | 4 | Per-channel high-impedance flag |

## Verification
Every result is due exactly three rising clock edges after a control input changes. Two of those edges are spent in the synchronizer. The third is the register update, which also covers the registered readback and enable outputs. The bench drives every input on a falling edge and samples on the third falling edge after the change. Load, clear and power-down are also sampled one edge earlier, to confirm the old value is still present. Bus data and address travel through a pipeline of the same depth, so they line up with the chip-select edge, and the bench holds them stable across it.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int CODE_W = 16;
    localparam int NCH    = 4;
    localparam int SEL_W  = $clog2(NCH);

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t [NCH-1:0] stage_rank;
        code_t [NCH-1:0] live_rank;
        code_t           rd_word;
        logic            rd_oe;
        logic [NCH-1:0]  hiz;
    } bank_state_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RST_VAL;
                    else        chain_q[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RST_VAL;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/qdac_edge.sv
module qdac_edge #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
    import qdac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stb,
    input  logic [SEL_W-1:0]       wr_sel,
    input  code_t                  wr_data,
    input  logic                   load_stb,
    input  logic                   clr_stb,
    input  logic                   rd_en,
    input  logic [SEL_W-1:0]       rd_sel,
    input  logic                   pd,
    output code_t [NCH-1:0]        stage_rank,
    output code_t [NCH-1:0]        live_rank,
    output code_t                  rd_word,
    output logic                   rd_oe,
    output logic [NCH-1:0]         hiz
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb) st_d.stage_rank[wr_sel] = wr_data;
        // clear outranks load when both arrive together
        if (clr_stb)       st_d.live_rank = '0;
        else if (load_stb) st_d.live_rank = st_q.stage_rank;
        st_d.rd_oe   = rd_en;
        st_d.rd_word = rd_en ? st_q.stage_rank[rd_sel] : '0;
        st_d.hiz     = {NCH{pd}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_rank = st_q.stage_rank;
    assign live_rank  = st_q.live_rank;
    assign rd_word    = st_q.rd_word;
    assign rd_oe      = st_q.rd_oe;
    assign hiz        = st_q.hiz;
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CODE_W-1:0]     bus_in,
    output logic [CODE_W-1:0]     bus_out,
    output logic                  bus_oe,
    input  logic [SEL_W-1:0]      addr,
    input  logic                  sel_n,
    input  logic                  rnw,
    input  logic                  load_in,
    input  logic                  clr_in,
    input  logic                  pwr_n,
    output logic [NCH*CODE_W-1:0] code_out,
    output logic [NCH-1:0]        out_hiz
);
    localparam int          CTL_W    = 5;
    localparam logic [4:0]  CTL_IDLE = 5'b11101; // pwr_n, clr, load, rnw, sel_n
    localparam int          DAT_W    = CODE_W + SEL_W;

    logic [CTL_W-1:0] ctl_s;
    logic [DAT_W-1:0] dat_s;
    logic sel_s, rnw_s, load_s, clr_s, pwr_s;
    logic sel_rise, ld_rise, clr_rise;
    code_t [NCH-1:0] stage_w, live_w;

    qdac_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) i_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({pwr_n, clr_in, load_in, rnw, sel_n}), .q(ctl_s)
    );

    qdac_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_dat_sync (
        .clk(clk), .rst_n(rst_n), .d({addr, bus_in}), .q(dat_s)
    );

    assign sel_s  = ctl_s[0];
    assign rnw_s  = ctl_s[1];
    assign load_s = ctl_s[2];
    assign clr_s  = ctl_s[3];
    assign pwr_s  = ctl_s[4];

    qdac_edge #(.IDLE(1'b1)) i_sel_edge  (.clk(clk), .rst_n(rst_n), .lvl(sel_s),  .rise(sel_rise));
    qdac_edge #(.IDLE(1'b1)) i_load_edge (.clk(clk), .rst_n(rst_n), .lvl(load_s), .rise(ld_rise));
    qdac_edge #(.IDLE(1'b1)) i_clr_edge  (.clk(clk), .rst_n(rst_n), .lvl(clr_s),  .rise(clr_rise));

    qdac_bank i_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(sel_rise & ~rnw_s),
        .wr_sel(dat_s[DAT_W-1:CODE_W]),
        .wr_data(dat_s[CODE_W-1:0]),
        .load_stb(ld_rise),
        .clr_stb(clr_rise),
        .rd_en(~sel_s & rnw_s),
        .rd_sel(dat_s[DAT_W-1:CODE_W]),
        .pd(~pwr_s),
        .stage_rank(stage_w),
        .live_rank(live_w),
        .rd_word(bus_out),
        .rd_oe(bus_oe),
        .hiz(out_hiz)
    );

    assign code_out = live_w;
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk
    import qdac_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sel_lvl,
    input logic                  pwr_lvl,
    input logic                  ld_rise,
    input logic                  clr_rise,
    input code_t [NCH-1:0]       stage_rank,
    input logic [NCH*CODE_W-1:0] code_out,
    input logic                  bus_oe,
    input logic [NCH-1:0]        out_hiz
);
    // R3
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_rise && !clr_rise) |=> $stable(code_out));
    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rise && !clr_rise) |=> (code_out == $past(stage_rank)));
    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rise |=> (code_out == '0));
    // R6
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && ld_rise) |=> (code_out == '0));
    // R8
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lvl |=> !bus_oe);
    // R9
    pd_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_lvl |=> (out_hiz == '1));
    // R9
    pd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_lvl && !ld_rise && !clr_rise) |=> $stable(code_out));
endmodule

bind quad_dac_regs qdac_chk i_qdac_chk (
    .clk(clk), .rst_n(rst_n), .sel_lvl(sel_s), .pwr_lvl(pwr_s),
    .ld_rise(ld_rise), .clr_rise(clr_rise), .stage_rank(stage_w),
    .code_out(code_out), .bus_oe(bus_oe), .out_hiz(out_hiz)
);

// File: tb/test_quad_dac_regs.sv
module test_quad_dac_regs;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe;
    logic [1:0]  addr = '0;
    logic        sel_n = 1'b1;
    logic        rnw = 1'b0;
    logic        load_in = 1'b1;
    logic        clr_in = 1'b1;
    logic        pwr_n = 1'b1;
    logic [63:0] code_out;
    logic [3:0]  out_hiz;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_stage [4];
    logic [15:0] m_live  [4];

    quad_dac_regs i_quad_dac_regs (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .addr(addr), .sel_n(sel_n), .rnw(rnw), .load_in(load_in), .clr_in(clr_in),
        .pwr_n(pwr_n), .code_out(code_out), .out_hiz(out_hiz)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [63:0] exp_codes();
        logic [63:0] v;
        for (int k = 0; k < 4; k++) v[16*k +: 16] = m_live[k];
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input int ch, input logic [15:0] val);
        rnw = 1'b0; addr = ch[1:0]; bus_in = val; sel_n = 1'b0;
        tick(3);
        sel_n = 1'b1;
        tick(3);
        m_stage[ch] = val;
        bus_in = 16'hdead;
    endtask

    task automatic do_read(input int ch, input string tag);
        rnw = 1'b1; addr = ch[1:0]; sel_n = 1'b0; bus_in = 16'h5a5a;
        tick(2);
        chk(bus_oe == 1'b0, {tag, " R13 oe early"}, {63'd0, bus_oe}, 64'd0);
        tick(1);
        chk(bus_oe == 1'b1, {tag, " R7 oe"}, {63'd0, bus_oe}, 64'd1);
        chk(bus_out == m_stage[ch], {tag, " R7 data"}, {48'd0, bus_out}, {48'd0, m_stage[ch]});
        sel_n = 1'b1;
        tick(3);
        chk(bus_oe == 1'b0, {tag, " R8 release"}, {63'd0, bus_oe}, 64'd0);
        rnw = 1'b0;
        tick(1);
    endtask

    task automatic do_load(input string tag);
        load_in = 1'b0;
        tick(3);
        load_in = 1'b1;
        tick(2);
        chk(code_out == exp_codes(), {tag, " R13 load early"}, code_out, exp_codes());
        for (int k = 0; k < 4; k++) m_live[k] = m_stage[k];
        tick(1);
        chk(code_out == exp_codes(), {tag, " R4 load"}, code_out, exp_codes());
    endtask

    task automatic do_clr(input string tag);
        clr_in = 1'b0;
        tick(3);
        clr_in = 1'b1;
        tick(2);
        chk(code_out == exp_codes(), {tag, " R13 clr early"}, code_out, exp_codes());
        for (int k = 0; k < 4; k++) m_live[k] = '0;
        tick(1);
        chk(code_out == 64'd0, {tag, " R5 clear"}, code_out, 64'd0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R13 actual %0d expected %0d", checks, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0d1ce));
        for (int k = 0; k < 4; k++) begin m_stage[k] = '0; m_live[k] = '0; end
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(code_out == 64'd0, "R1 codes", code_out, 64'd0);
        chk(out_hiz == 4'h0, "R1 hiz", {60'd0, out_hiz}, 64'd0);
        chk(bus_oe == 1'b0, "R1 bus", {63'd0, bus_oe}, 64'd0);

        // R2 / R3: fill staging, live stays zero
        do_write(0, 16'h1111); do_write(1, 16'h2222);
        do_write(2, 16'h3333); do_write(3, 16'h4444);
        chk(code_out == 64'd0, "R3 no load yet", code_out, 64'd0);
        for (int k = 0; k < 4; k++) do_read(k, "R2 readback");
        do_load("R4 first");

        // R12 extremes
        do_write(2, 16'hffff); do_write(1, 16'h0000);
        chk(code_out == exp_codes(), "R3 write holds live", code_out, exp_codes());
        do_read(2, "R12 max");
        do_load("R12 extremes");

        // R11: end of a read writes nothing
        do_read(3, "R11 first");
        do_read(3, "R11 again");

        // R5 clear keeps staging
        do_clr("R5");
        for (int k = 0; k < 4; k++) do_read(k, "R5 staging kept");

        // R6 simultaneous load and clear
        do_load("R6 preload");
        load_in = 1'b0; clr_in = 1'b0;
        tick(3);
        load_in = 1'b1; clr_in = 1'b1;
        tick(3);
        for (int k = 0; k < 4; k++) m_live[k] = '0;
        chk(code_out == 64'd0, "R6 clear wins", code_out, 64'd0);

        // R9 power-down hold and return
        do_load("R9 preload");
        pwr_n = 1'b0;
        tick(2);
        chk(out_hiz == 4'h0, "R13 pd early", {60'd0, out_hiz}, 64'd0);
        tick(1);
        chk(out_hiz == 4'hf, "R9 hiz", {60'd0, out_hiz}, 64'hf);
        // R8 load with chip select high, during power-down
        do_write(0, 16'hbeef);
        do_load("R8 load while deselected");
        pwr_n = 1'b1;
        tick(3);
        chk(out_hiz == 4'h0, "R9 wake", {60'd0, out_hiz}, 64'd0);
        chk(code_out == exp_codes(), "R9 codes back", code_out, exp_codes());

        // R10 clear during power-down
        pwr_n = 1'b0;
        tick(3);
        do_clr("R10");
        pwr_n = 1'b1;
        tick(3);
        chk(out_hiz == 4'h0 && code_out == 64'd0, "R10 zero after wake", code_out, 64'd0);

        // random mix
        for (int i = 0; i < 160; i++) begin
            int op;
            int ch;
            op = int'($urandom_range(0, 9));
            ch = int'($urandom_range(0, 3));
            if (op < 4)       do_write(ch, 16'($urandom));
            else if (op < 7)  do_read(ch, "R7 random");
            else if (op < 9)  do_load("R4 random");
            else              do_clr("R5 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule